// File: doc/BRIEF.md
# Return-Address Stack and Next-PC Selector

This block chooses the next program counter of a small soft processor and keeps the stack of return addresses for subroutine calls. Each cycle the instruction decoder raises at most one operation strobe: a call to an immediate 12-bit address, a call whose target is built from two 8-bit general registers, a return, or a combined operation that returns and also writes an 8-bit constant into a register. The block answers in the same cycle with the address to fetch next. Any stack push or pop takes effect at the following clock edge.

The program counter register itself sits outside the block. The current PC comes in as an input and the next PC goes out as a combinational output. Flag evaluation also sits outside: a single `condTrue` input tells whether the condition of a conditional call or return holds. The register write of the load-and-return operation leaves the block as a request with an address and data. Two one-cycle fault pulses report a push into a full stack and a pop from an empty one.

Top module: `pc_call_stack`

## Requirements
- R1: With no operation strobe active, `nextPc` equals `pcCur + 1` modulo 4096, so 0xFFF is followed by 0x000.
- R2: With `opCall` high and `condTrue` high, `nextPc` equals `immTarget`, `pcCur` is pushed and `depth` rises by one at the next edge. With `condTrue` low, the cycle behaves exactly as R1 and nothing is pushed.
- R3: `opCallInd` is unconditional. `nextPc` is `{regHi[3:0], regLo}` (the upper four bits of `regHi` are ignored), and `pcCur` is pushed.
- R4: With `opReturn` high and `condTrue` high, `nextPc` equals the most recently pushed address plus one (modulo 4096), and that entry is popped. With `condTrue` low, the cycle behaves as R1.
- R5: `opLoadRet` is unconditional. It returns as in R4, and in the same cycle drives `regWrEn` high, `regWrData` equal to `constIn` and `regWrAddr` equal to `dstSel`. In every other cycle `regWrEn` is low.
- R6: Up to 30 addresses are held and come back in last-in first-out order. `depth` reports the number held.
- R7: A push while 30 entries are held raises `overflowFlag` after the next edge, sets `depth` to 0 and discards every entry. `nextPc` still takes the call target.
- R8: A pop while the stack is empty raises `underflowFlag` after the next edge and leaves `depth` at 0. `nextPc` becomes `pcCur + 1`. A load-and-return on an empty stack still makes its register write.
- R9: While `rstN` is low, `depth` is 0 and both fault flags are low, whatever the stack held before.
- R10: When several strobes are high at once, only the highest in the order `opCall`, `opCallInd`, `opReturn`, `opLoadRet` is considered. If that strobe's condition is false, the cycle behaves as R1.
- R11: Each fault flag is high for exactly one cycle per offending operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCall | input | 1 | Call to immediate target (conditional) |
| opCallInd | input | 1 | Call to register-pair target |
| opReturn | input | 1 | Return (conditional) |
| opLoadRet | input | 1 | Return plus constant register write |
| condTrue | input | 1 | Condition of a conditional call or return holds |
| pcCur | input | 12 | Current program counter |
| immTarget | input | 12 | Immediate call target |
| regHi | input | 8 | Register supplying target bits 11:8 (low nibble) |
| regLo | input | 8 | Register supplying target bits 7:0 |
| constIn | input | 8 | Constant for the load-and-return write |
| dstSel | input | 4 | Destination register index for the write |
| nextPc | output | 12 | Address to fetch next |
| depth | output | 5 | Number of stacked return addresses |
| overflowFlag | output | 1 | One-cycle pulse after a push into a full stack |
| underflowFlag | output | 1 | One-cycle pulse after a pop from an empty stack |
| regWrEn | output | 1 | Register write request |
| regWrData | output | 8 | Register write data |
| regWrAddr | output | 4 | Register write index |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 8-bit registers and 30 stack entries. With these values, filling the stack completely and draining it again takes only sixty cycles. The bench therefore exercises the full last-in first-out order, including the wrap from a stored 0xFFF to 0x000 on return. It also exercises the push at full depth that clears the stack and both pop-on-empty cases. The 4096-address wrap of the plain increment and the ignored upper nibble of the high register are likewise reachable directly at these sizes.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Source selection for the next program counter
  typedef enum logic [1:0] {
    SRC_INC  = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_PAIR = 2'd2,
    SRC_RET  = 2'd3
  } pcSrc_e;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic   push;
    logic   pop;
    logic   wrReq;
    pcSrc_e src;
  } stackCtl_t;

endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      opCall,
  input  logic      opCallInd,
  input  logic      opReturn,
  input  logic      opLoadRet,
  input  logic      condTrue,
  output stackCtl_t ctl
);

  // Fixed priority: the highest asserted strobe alone decides the cycle
  always_comb begin
    ctl       = '0;
    ctl.src   = SRC_INC;
    if (opCall) begin
      if (condTrue) begin
        ctl.push = 1'b1;
        ctl.src  = SRC_IMM;
      end
    end else if (opCallInd) begin
      ctl.push = 1'b1;
      ctl.src  = SRC_PAIR;
    end else if (opReturn) begin
      if (condTrue) begin
        ctl.pop = 1'b1;
        ctl.src = SRC_RET;
      end
    end else if (opLoadRet) begin
      ctl.pop   = 1'b1;
      ctl.wrReq = 1'b1;
      ctl.src   = SRC_RET;
    end
  end

  AST_CALL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (opCall && !condTrue) |-> (!ctl.push && !ctl.pop && ctl.src == SRC_INC)); // R2
  AST_CALL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (opCall && condTrue && (opReturn || opLoadRet)) |-> (ctl.push && !ctl.wrReq)); // R10
  AST_LOADRET_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opLoadRet && !opCall && !opCallInd && !opReturn) |-> (ctl.pop && ctl.wrReq)); // R5
  AST_WRITE_NEEDS_LOADRET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrReq |-> opLoadRet); // R5

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int REG_W   = 8,
  parameter int SEL_W   = 4,
  parameter int DEPTH   = 30,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  stackCtl_t          ctl,
  input  logic [ADDR_W-1:0]  pcCur,
  input  logic [ADDR_W-1:0]  immTarget,
  input  logic [REG_W-1:0]   regHi,
  input  logic [REG_W-1:0]   regLo,
  input  logic [REG_W-1:0]   constIn,
  input  logic [SEL_W-1:0]   dstSel,
  output logic [ADDR_W-1:0]  nextPc,
  output logic [DEPTH_W-1:0] depth,
  output logic               overflowFlag,
  output logic               underflowFlag,
  output logic               regWrEn,
  output logic [REG_W-1:0]   regWrData,
  output logic [SEL_W-1:0]   regWrAddr
);

  localparam logic [DEPTH_W-1:0] FULL_CNT = DEPTH_W'(DEPTH);

  logic [DEPTH_W-1:0] ptr;
  logic [ADDR_W-1:0]  entry [DEPTH];
  logic [DEPTH-1:0]   entryWe;
  logic [DEPTH_W-1:0] topIdx;
  logic [ADDR_W-1:0]  topEntry;
  logic               isEmpty;
  logic               isFull;
  logic [ADDR_W-1:0]  pcInc;
  logic [ADDR_W-1:0]  retAddr;
  logic [ADDR_W-1:0]  pairTarget;

  assign isEmpty  = (ptr == '0);
  assign isFull   = (ptr == FULL_CNT);
  assign topIdx   = isEmpty ? '0 : DEPTH_W'(ptr - 1'b1);
  assign topEntry = entry[topIdx];
  assign pcInc    = ADDR_W'(pcCur + 1'b1);
  assign retAddr  = ADDR_W'(topEntry + 1'b1);
  // Register pair: low bits of the high register over the full low register
  assign pairTarget = ADDR_W'({regHi, regLo});

  // One write enable and one storage word per stack slot
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    assign entryWe[g] = ctl.push && !isFull && (ptr == DEPTH_W'(g));
    always_ff @(posedge clk) begin
      if (entryWe[g]) entry[g] <= pcCur;
    end
  end

  // Pointer and fault pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr           <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
      if (ctl.push) begin
        if (isFull) begin
          ptr          <= '0;
          overflowFlag <= 1'b1;
        end else begin
          ptr <= DEPTH_W'(ptr + 1'b1);
        end
      end else if (ctl.pop) begin
        if (isEmpty) underflowFlag <= 1'b1;
        else         ptr <= DEPTH_W'(ptr - 1'b1);
      end
    end
  end

  // Next program counter
  always_comb begin
    unique case (ctl.src)
      SRC_IMM:  nextPc = immTarget;
      SRC_PAIR: nextPc = pairTarget;
      SRC_RET:  nextPc = isEmpty ? pcInc : retAddr;
      default:  nextPc = pcInc;
    endcase
  end

  assign depth     = ptr;
  assign regWrEn   = ctl.wrReq;
  assign regWrData = constIn;
  assign regWrAddr = dstSel;

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= FULL_CNT); // R6
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !isFull) |=> (ptr == DEPTH_W'($past(ptr) + 1'b1))); // R2
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !isFull) |=> (topEntry == $past(pcCur))); // R6
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && !ctl.push && !isEmpty) |=> (ptr == DEPTH_W'($past(ptr) - 1'b1))); // R4
  AST_NO_OVERFLOW_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && isFull) |=> (overflowFlag && ptr == '0)); // R7
  AST_UNDERFLOW_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && !ctl.push && isEmpty) |=> (underflowFlag && ptr == '0)); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(overflowFlag && underflowFlag)); // R11
  AST_EMPTY_POP_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && isEmpty) |-> (nextPc == pcInc)); // R8

endmodule

// File: rtl/pc_call_stack.sv
module pc_call_stack
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int REG_W   = 8,
  parameter int SEL_W   = 4,
  parameter int DEPTH   = 30,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opCall,
  input  logic               opCallInd,
  input  logic               opReturn,
  input  logic               opLoadRet,
  input  logic               condTrue,
  input  logic [ADDR_W-1:0]  pcCur,
  input  logic [ADDR_W-1:0]  immTarget,
  input  logic [REG_W-1:0]   regHi,
  input  logic [REG_W-1:0]   regLo,
  input  logic [REG_W-1:0]   constIn,
  input  logic [SEL_W-1:0]   dstSel,
  output logic [ADDR_W-1:0]  nextPc,
  output logic [DEPTH_W-1:0] depth,
  output logic               overflowFlag,
  output logic               underflowFlag,
  output logic               regWrEn,
  output logic [REG_W-1:0]   regWrData,
  output logic [SEL_W-1:0]   regWrAddr
);

  stackCtl_t ctl;

  pcs_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opCall    (opCall),
    .opCallInd (opCallInd),
    .opReturn  (opReturn),
    .opLoadRet (opLoadRet),
    .condTrue  (condTrue),
    .ctl       (ctl)
  );

  pcs_stack #(
    .ADDR_W  (ADDR_W),
    .REG_W   (REG_W),
    .SEL_W   (SEL_W),
    .DEPTH   (DEPTH),
    .DEPTH_W (DEPTH_W)
  ) i_stack (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .pcCur         (pcCur),
    .immTarget     (immTarget),
    .regHi         (regHi),
    .regLo         (regLo),
    .constIn       (constIn),
    .dstSel        (dstSel),
    .nextPc        (nextPc),
    .depth         (depth),
    .overflowFlag  (overflowFlag),
    .underflowFlag (underflowFlag),
    .regWrEn       (regWrEn),
    .regWrData     (regWrData),
    .regWrAddr     (regWrAddr)
  );

endmodule

// File: tb/test_pc_call_stack.sv
module test_pc_call_stack;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int REG_W  = 8;
  localparam int SEL_W  = 4;
  localparam int DEPTH  = 30;
  localparam int DEPTH_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opCall = 1'b0, opCallInd = 1'b0, opReturn = 1'b0, opLoadRet = 1'b0;
  logic condTrue = 1'b0;
  logic [ADDR_W-1:0] pcCur = '0, immTarget = '0;
  logic [REG_W-1:0] regHi = '0, regLo = '0, constIn = '0;
  logic [SEL_W-1:0] dstSel = '0;
  logic [ADDR_W-1:0] nextPc;
  logic [DEPTH_W-1:0] depth;
  logic overflowFlag, underflowFlag, regWrEn;
  logic [REG_W-1:0] regWrData;
  logic [SEL_W-1:0] regWrAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_call_stack i_pc_call_stack (
    .clk(clk), .rstN(rstN), .opCall(opCall), .opCallInd(opCallInd),
    .opReturn(opReturn), .opLoadRet(opLoadRet), .condTrue(condTrue),
    .pcCur(pcCur), .immTarget(immTarget), .regHi(regHi), .regLo(regLo),
    .constIn(constIn), .dstSel(dstSel), .nextPc(nextPc), .depth(depth),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag),
    .regWrEn(regWrEn), .regWrData(regWrData), .regWrAddr(regWrAddr)
  );

  typedef struct {
    logic [ADDR_W-1:0] pc;
    logic              wr;
    logic [REG_W-1:0]  wd;
    logic [SEL_W-1:0]  wa;
    int                dep;
    logic              ovf;
    logic              udf;
    string             tag;
  } expItem_t;

  expItem_t sbQ[$];
  logic [ADDR_W-1:0] mStack[$];
  logic mOvf = 1'b0, mUdf = 1'b0;
  int checks = 0;
  int fails  = 0;

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one operation and queues the expected observation
  task automatic applyOp(input logic c, input logic ci, input logic r, input logic lr,
                         input logic cond, input logic [ADDR_W-1:0] pc,
                         input logic [ADDR_W-1:0] imm, input logic [REG_W-1:0] hi,
                         input logic [REG_W-1:0] lo, input logic [REG_W-1:0] k,
                         input logic [SEL_W-1:0] sel, input string tag);
    expItem_t it;
    logic doPush, doPop;
    @(negedge clk);
    opCall = c; opCallInd = ci; opReturn = r; opLoadRet = lr; condTrue = cond;
    pcCur = pc; immTarget = imm; regHi = hi; regLo = lo; constIn = k; dstSel = sel;
    it.dep = mStack.size(); it.ovf = mOvf; it.udf = mUdf; it.tag = tag;
    it.pc = pc + 12'd1; it.wr = 1'b0; it.wd = k; it.wa = sel;
    doPush = 1'b0; doPop = 1'b0;
    if (c) begin
      if (cond) begin it.pc = imm; doPush = 1'b1; end
    end else if (ci) begin
      it.pc = {hi[3:0], lo}; doPush = 1'b1;
    end else if (r) begin
      if (cond) doPop = 1'b1;
    end else if (lr) begin
      it.wr = 1'b1; doPop = 1'b1;
    end
    mOvf = 1'b0; mUdf = 1'b0;
    if (doPush) begin
      if (mStack.size() == DEPTH) begin mOvf = 1'b1; mStack.delete(); end
      else mStack.push_back(pc);
    end
    if (doPop) begin
      if (mStack.size() == 0) mUdf = 1'b1;
      else it.pc = mStack.pop_back() + 12'd1;
    end
    sbQ.push_back(it);
  endtask

  task automatic idle(input logic [ADDR_W-1:0] pc, input string tag);
    applyOp(0, 0, 0, 0, 0, pc, '0, '0, '0, '0, '0, tag);
  endtask

  // Monitor: compares outputs a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sbQ.size() > 0) begin
        expItem_t e;
        e = sbQ.pop_front();
        cmp(e.tag, "nextPc", 32'(nextPc), 32'(e.pc));
        cmp(e.tag, "regWrEn", 32'(regWrEn), 32'(e.wr));
        if (e.wr) begin
          cmp(e.tag, "regWrData", 32'(regWrData), 32'(e.wd));
          cmp(e.tag, "regWrAddr", 32'(regWrAddr), 32'(e.wa));
        end
        cmp(e.tag, "depth", 32'(depth), 32'(e.dep));
        cmp(e.tag, "overflowFlag", 32'(overflowFlag), 32'(e.ovf));
        cmp(e.tag, "underflowFlag", 32'(underflowFlag), 32'(e.udf));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state, with a call strobe present during reset
    opCall = 1'b1; condTrue = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    cmp("R9", "depth", 32'(depth), 0);
    cmp("R9", "overflowFlag", 32'(overflowFlag), 0);
    cmp("R9", "underflowFlag", 32'(underflowFlag), 0);
    opCall = 1'b0; condTrue = 1'b0;
    rstN = 1'b1;

    idle(12'h123, "R1");
    idle(12'hFFF, "R1 wrap");
    applyOp(1, 0, 0, 0, 1, 12'h100, 12'h456, 8'h00, 8'h00, 8'h00, 4'h0, "R2");
    applyOp(1, 0, 0, 0, 0, 12'h200, 12'h999, 8'h00, 8'h00, 8'h00, 4'h0, "R2 not taken");
    applyOp(0, 1, 0, 0, 0, 12'h456, 12'h000, 8'hA7, 8'h3C, 8'h00, 4'h0, "R3");
    idle(12'h73C, "R6 depth");
    applyOp(0, 0, 1, 0, 1, 12'h73C, 12'h000, 8'h00, 8'h00, 8'h00, 4'h0, "R4");
    applyOp(0, 0, 1, 0, 0, 12'h457, 12'h000, 8'h00, 8'h00, 8'h00, 4'h0, "R4 not taken");
    applyOp(0, 0, 0, 1, 0, 12'h458, 12'h000, 8'h00, 8'h00, 8'h5A, 4'h3, "R5");
    applyOp(0, 0, 1, 0, 1, 12'h300, 12'h000, 8'h00, 8'h00, 8'h00, 4'h0, "R8");
    applyOp(0, 0, 0, 1, 0, 12'hFFF, 12'h000, 8'h00, 8'h00, 8'h11, 4'hF, "R8 loadret");
    idle(12'h010, "R8 flag");
    idle(12'h011, "R11 flag clear");

    // R6: fill to full depth and drain in LIFO order
    for (int i = 0; i < DEPTH; i++)
      applyOp(1, 0, 0, 0, 1, (i == DEPTH-1) ? 12'hFFF : 12'(i * 33 + 5),
              12'(12'h800 + i), 8'h00, 8'h00, 8'h00, 4'h0, "R6 fill");
    for (int i = 0; i < DEPTH; i++)
      applyOp(0, 0, 1, 0, 1, 12'h020, 12'h000, 8'h00, 8'h00, 8'h00, 4'h0, "R6 drain");
    idle(12'h021, "R6 empty");

    // R7: overflow on the 31st push
    for (int i = 0; i < DEPTH; i++)
      applyOp(0, 1, 0, 0, 0, 12'(i + 64), 12'h000, 8'hF2, 8'(i), 8'h00, 4'h0, "R7 fill");
    applyOp(1, 0, 0, 0, 1, 12'h040, 12'hABC, 8'h00, 8'h00, 8'h00, 4'h0, "R7 push full");
    idle(12'h050, "R7 flag");
    idle(12'h051, "R11 overflow clear");
    applyOp(0, 0, 1, 0, 1, 12'h052, 12'h000, 8'h00, 8'h00, 8'h00, 4'h0, "R7 emptied");

    // R10: priority among simultaneous strobes
    applyOp(1, 0, 1, 1, 1, 12'h060, 12'h321, 8'h00, 8'h00, 8'h77, 4'h2, "R10 call wins");
    applyOp(1, 1, 0, 0, 0, 12'h070, 12'h321, 8'h05, 8'h55, 8'h00, 4'h0, "R10 false call");
    applyOp(0, 1, 1, 1, 1, 12'h080, 12'h000, 8'h0B, 8'hCD, 8'h00, 4'h0, "R10 ind wins");
    applyOp(0, 0, 1, 1, 0, 12'h090, 12'h000, 8'h00, 8'h00, 8'h33, 4'h1, "R10 false ret");
    idle(12'h0A0, "R10 depth");

    // R9: reset while the stack holds entries
    wait (sbQ.size() == 0);
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    rstN = 1'b0;
    #1;
    cmp("R9 mid", "depth", 32'(depth), 0);
    mStack.delete(); mOvf = 1'b0; mUdf = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    applyOp(0, 0, 1, 0, 1, 12'h0B0, 12'h000, 8'h00, 8'h00, 8'h00, 4'h0, "R9 after");
    idle(12'h0B1, "R9 underflow");

    wait (sbQ.size() == 0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule